// File: doc/BRIEF.md
# Oscillator Tuning Word Selector with Frequency Clamp

This block forms the frequency tuning word for the numerically controlled oscillator of a digital PLL. The loop's operating mode picks one of three candidate words. The first is a programmed word used when the loop runs open. The second is the live output of the loop filter while the loop is locked. The third is an averaged history word, used when the loop coasts without a reference. Each candidate comes with a sample strobe. The output register takes a new value only when the strobe of the currently selected source fires.

The selected word then passes through a frequency window with an upper bound and a lower bound. Each bound is a 24-bit value N and stands for the frequency fs·N/2^24. It is compared against the most significant 24 bits of the 48-bit word. A word outside the window is replaced by the violated bound, with its low bits cleared, and a flag shows which bound acted. The window applies in every mode. The bounds are held in registers inside the block and are loaded by a one-cycle load pulse. After reset they cover the whole range, so the window has no effect until new bounds are loaded.

Top module: `tw_select_clamp`

## Requirements
- R1: After reset the output word is 0, both clamp flags are 0, the upper bound is all ones and the lower bound is 0. With these bounds, any word (including 0 and all ones) reaches the output unchanged.
- R2: The mode input is encoded as 0 = open loop, 1 = locked and 2 = coasting; code 3 behaves like code 0. In open loop, the output equals the open-loop word one clock after its strobe.
- R3: In locked mode, the output follows the loop filter word. Each loop filter strobe loads the word presented with it, one clock later.
- R4: In coasting mode with the history-valid input high, the output takes the history word one clock after the history strobe.
- R5: In coasting mode with history-valid low, the block uses the open-loop word and the open-loop strobe. A history strobe then leaves the output unchanged.
- R6: The output and its flags change only on the clock edge that follows a strobe of the selected source. Strobes of the other sources, mode changes and bound loads leave them as they are.
- R7: When the top 24 bits of the selected word exceed the upper bound, the output becomes {upper, 24'h0} and the upper flag is 1.
- R8: When the top 24 bits are below the lower bound, and R7 and R10 do not apply, the output becomes {lower, 24'h0} and the lower flag is 1. At most one flag is ever 1.
- R9: When the top 24 bits lie between the bounds (inclusive), the word passes unchanged whatever its low bits are, and both flags are 0.
- R10: When the lower bound is above the upper bound, the upper bound wins. Every word then becomes {upper, 24'h0} with the upper flag set.
- R11: A load pulse writes both bounds on the next clock edge. The new bounds take effect from the next output update, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Loop mode: 0 open loop, 1 locked, 2 coasting, 3 as 0 |
| open_word | input | 48 | Programmed open-loop tuning word |
| open_stb | input | 1 | Sample strobe for open_word |
| filt_word | input | 48 | Loop filter tuning word |
| filt_stb | input | 1 | Sample strobe for filt_word |
| hist_word | input | 48 | Averaged history tuning word |
| hist_stb | input | 1 | Sample strobe for hist_word |
| hist_valid | input | 1 | History word holds a usable average |
| bound_load | input | 1 | Load pulse for both bounds |
| bound_hi_in | input | 24 | Upper bound value to load |
| bound_lo_in | input | 24 | Lower bound value to load |
| tw_out | output | 48 | Clamped tuning word, registered |
| at_upper | output | 1 | Last update was limited by the upper bound |
| at_lower | output | 1 | Last update was limited by the lower bound |

## Verification
The output is a register that updates only on a strobe. A wrong internal state therefore shows at the ports one clock after the next strobe of the selected source, and it stays visible until the following strobe. A wrong bound register or a wrong comparison gives a word that differs from the expected bound or from the pass-through value. The flag pair then disagrees with the word. A wrong source selection loads the word of the wrong source, or it moves the output on a strobe that should have no effect. The bench catches this by loading each source with a distinct value.

// File: rtl/tw_sel_pkg.sv
package tw_sel_pkg;

   typedef enum logic [1:0] {
      TW_MODE_OPEN  = 2'd0,
      TW_MODE_LOCK  = 2'd1,
      TW_MODE_COAST = 2'd2,
      TW_MODE_RSVD  = 2'd3
   } tw_mode_e;

   typedef struct packed {
      logic hi;
      logic lo;
   } tw_flags_t;

endpackage

// File: rtl/tw_src_mux.sv
module tw_src_mux
   import tw_sel_pkg::*;
#(
   parameter int TW_W = 48
) (
   input  tw_mode_e          mode,
   input  logic [TW_W-1:0]   open_word,
   input  logic              open_stb,
   input  logic [TW_W-1:0]   filt_word,
   input  logic              filt_stb,
   input  logic [TW_W-1:0]   hist_word,
   input  logic              hist_stb,
   input  logic              hist_valid,
   output logic [TW_W-1:0]   sel_word,
   output logic              sel_stb
);

   always_comb begin
      sel_word = open_word;
      sel_stb  = open_stb;
      unique case (mode)
         TW_MODE_LOCK: begin
            sel_word = filt_word;
            sel_stb  = filt_stb;
         end
         TW_MODE_COAST: begin
            if (hist_valid) begin
               sel_word = hist_word;
               sel_stb  = hist_stb;
            end
         end
         default: begin
            sel_word = open_word;
            sel_stb  = open_stb;
         end
      endcase
   end

endmodule

// File: rtl/tw_bound_regs.sv
module tw_bound_regs #(
   parameter int LIM_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LIM_W-1:0] hi_in,
   input  logic [LIM_W-1:0] lo_in,
   output logic [LIM_W-1:0] hi_q,
   output logic [LIM_W-1:0] lo_q
);

   localparam logic [LIM_W-1:0] HI_RST = {LIM_W{1'b1}};
   localparam logic [LIM_W-1:0] LO_RST = '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= HI_RST;
         lo_q <= LO_RST;
      end else if (load) begin
         hi_q <= hi_in;
         lo_q <= lo_in;
      end
   end

   // R11: bound registers move only on a load pulse
   a_r11_bounds_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/tw_clamp.sv
module tw_clamp
   import tw_sel_pkg::*;
#(
   parameter int TW_W  = 48,
   parameter int LIM_W = 24
) (
   input  logic [TW_W-1:0]  word_i,
   input  logic [LIM_W-1:0] hi_lim,
   input  logic [LIM_W-1:0] lo_lim,
   output logic [TW_W-1:0]  word_o,
   output tw_flags_t        flags_o
);

   localparam int PAD_W = TW_W - LIM_W;

   logic [LIM_W-1:0] top;
   logic [TW_W-1:0]  hi_full;
   logic [TW_W-1:0]  lo_full;
   logic             inverted;

   assign top      = word_i[TW_W-1 -: LIM_W];
   assign inverted = lo_lim > hi_lim;

   generate
      if (PAD_W > 0) begin : g_pad
         assign hi_full = {hi_lim, {PAD_W{1'b0}}};
         assign lo_full = {lo_lim, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign hi_full = hi_lim;
         assign lo_full = lo_lim;
      end
   endgenerate

   always_comb begin
      word_o     = word_i;
      flags_o.hi = 1'b0;
      flags_o.lo = 1'b0;
      if (inverted || (top > hi_lim)) begin
         word_o     = hi_full;
         flags_o.hi = 1'b1;
      end else if (top < lo_lim) begin
         word_o     = lo_full;
         flags_o.lo = 1'b1;
      end
   end

endmodule

// File: rtl/tw_select_clamp.sv
module tw_select_clamp
   import tw_sel_pkg::*;
#(
   parameter int TW_W  = 48,
   parameter int LIM_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic [TW_W-1:0]   open_word,
   input  logic              open_stb,
   input  logic [TW_W-1:0]   filt_word,
   input  logic              filt_stb,
   input  logic [TW_W-1:0]   hist_word,
   input  logic              hist_stb,
   input  logic              hist_valid,
   input  logic              bound_load,
   input  logic [LIM_W-1:0]  bound_hi_in,
   input  logic [LIM_W-1:0]  bound_lo_in,
   output logic [TW_W-1:0]   tw_out,
   output logic              at_upper,
   output logic              at_lower
);

   generate
      if (LIM_W < 1 || LIM_W > TW_W) begin : g_bad_lim
         $error("tw_select_clamp: LIM_W must lie in 1..TW_W");
      end
      if (TW_W < 2) begin : g_bad_tw
         $error("tw_select_clamp: TW_W too small");
      end
   endgenerate

   tw_mode_e         mode_e;
   logic [TW_W-1:0]  sel_word;
   logic             sel_stb;
   logic [LIM_W-1:0] lim_hi_q;
   logic [LIM_W-1:0] lim_lo_q;
   logic [TW_W-1:0]  cl_word;
   tw_flags_t        cl_flags;
   logic [TW_W-1:0]  tw_q;
   tw_flags_t        flags_q;

   assign mode_e = tw_mode_e'(mode);

   tw_src_mux #(.TW_W(TW_W)) u_mux (
      .mode       (mode_e),
      .open_word  (open_word),
      .open_stb   (open_stb),
      .filt_word  (filt_word),
      .filt_stb   (filt_stb),
      .hist_word  (hist_word),
      .hist_stb   (hist_stb),
      .hist_valid (hist_valid),
      .sel_word   (sel_word),
      .sel_stb    (sel_stb)
   );

   tw_bound_regs #(.LIM_W(LIM_W)) u_bounds (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (bound_load),
      .hi_in (bound_hi_in),
      .lo_in (bound_lo_in),
      .hi_q  (lim_hi_q),
      .lo_q  (lim_lo_q)
   );

   tw_clamp #(.TW_W(TW_W), .LIM_W(LIM_W)) u_clamp (
      .word_i  (sel_word),
      .hi_lim  (lim_hi_q),
      .lo_lim  (lim_lo_q),
      .word_o  (cl_word),
      .flags_o (cl_flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tw_q    <= '0;
         flags_q <= '0;
      end else if (sel_stb) begin
         tw_q    <= cl_word;
         flags_q <= cl_flags;
      end
   end

   assign tw_out   = tw_q;
   assign at_upper = flags_q.hi;
   assign at_lower = flags_q.lo;

   // R6: no strobe on the selected source, no change at the output
   a_r6_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sel_stb) |-> ($stable(tw_q) && $stable(flags_q)));

   // R5: a history strobe without valid history and without an open-loop strobe is ignored
   a_r5_fallback_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !hist_valid && hist_stb && !open_stb) |=> $stable(tw_q));

   // R8: the two flags never assert together
   a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({at_upper, at_lower}));

   // R9: with ordered bounds the clamped word lies inside the window
   a_r9_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_lo_q <= lim_hi_q) |->
         (cl_word[TW_W-1 -: LIM_W] <= lim_hi_q && cl_word[TW_W-1 -: LIM_W] >= lim_lo_q));

   // R9: unflagged words are passed bit for bit
   a_r9_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (!cl_flags.hi && !cl_flags.lo) |-> (cl_word == sel_word));

   // R10: inverted bounds always give the upper flag
   a_r10_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_lo_q > lim_hi_q) |-> (cl_flags.hi && !cl_flags.lo));

endmodule

// File: tb/tw_select_clamp_bench.sv
module tw_select_clamp_bench;

   localparam int TW_W  = 48;
   localparam int LIM_W = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode = 2'd0;
   logic [TW_W-1:0]   open_word = '0;
   logic              open_stb = 1'b0;
   logic [TW_W-1:0]   filt_word = '0;
   logic              filt_stb = 1'b0;
   logic [TW_W-1:0]   hist_word = '0;
   logic              hist_stb = 1'b0;
   logic              hist_valid = 1'b0;
   logic              bound_load = 1'b0;
   logic [LIM_W-1:0]  bound_hi_in = '0;
   logic [LIM_W-1:0]  bound_lo_in = '0;
   logic [TW_W-1:0]   tw_out;
   logic              at_upper;
   logic              at_lower;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tw_select_clamp #(.TW_W(TW_W), .LIM_W(LIM_W)) u_tw_select_clamp (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .open_word(open_word), .open_stb(open_stb),
      .filt_word(filt_word), .filt_stb(filt_stb),
      .hist_word(hist_word), .hist_stb(hist_stb), .hist_valid(hist_valid),
      .bound_load(bound_load), .bound_hi_in(bound_hi_in), .bound_lo_in(bound_lo_in),
      .tw_out(tw_out), .at_upper(at_upper), .at_lower(at_lower)
   );

   task automatic chk(input string req, input logic [TW_W-1:0] exp_w,
                      input logic exp_hi, input logic exp_lo);
      checks++;
      if (tw_out !== exp_w || at_upper !== exp_hi || at_lower !== exp_lo) begin
         errors++;
         $display("FAIL %s: got word=%h hi=%b lo=%b, expected word=%h hi=%b lo=%b",
                  req, tw_out, at_upper, at_lower, exp_w, exp_hi, exp_lo);
      end
   endtask

   // pulse: 0 open, 1 filter, 2 history; output sampled at the following falling edge
   task automatic pulse(input int src);
      @(negedge clk);
      open_stb = (src == 0);
      filt_stb = (src == 1);
      hist_stb = (src == 2);
      @(negedge clk);
      open_stb = 1'b0;
      filt_stb = 1'b0;
      hist_stb = 1'b0;
   endtask

   task automatic load_bounds(input logic [LIM_W-1:0] hi, input logic [LIM_W-1:0] lo);
      @(negedge clk);
      bound_hi_in = hi;
      bound_lo_in = lo;
      bound_load  = 1'b1;
      @(negedge clk);
      bound_load  = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 reset state", '0, 1'b0, 1'b0);
      mode = 2'd0;
      open_word = 48'hFFFF_FFFF_FFFF;
      pulse(0);
      chk("R1 default bounds pass all ones", 48'hFFFF_FFFF_FFFF, 1'b0, 1'b0);
      open_word = 48'h0;
      pulse(0);
      chk("R1 default bounds pass zero", 48'h0, 1'b0, 1'b0);
   endtask

   task automatic t_open_loop();
      mode = 2'd0;
      open_word = 48'h1234_5678_9ABC;
      pulse(0);
      chk("R2 open-loop word", 48'h1234_5678_9ABC, 1'b0, 1'b0);
      mode = 2'd3;
      open_word = 48'h0A0B_0C0D_0E0F;
      pulse(0);
      chk("R2 code 3 acts as open loop", 48'h0A0B_0C0D_0E0F, 1'b0, 1'b0);
   endtask

   task automatic t_locked();
      mode = 2'd1;
      for (int i = 0; i < 3; i++) begin
         filt_word = 48'h4000_0000_0000 + 48'(i) * 48'h0011_2233_4455;
         pulse(1);
         chk("R3 filter word tracked", 48'h4000_0000_0000 + 48'(i) * 48'h0011_2233_4455,
             1'b0, 1'b0);
      end
   endtask

   task automatic t_coast();
      mode = 2'd2;
      hist_valid = 1'b1;
      hist_word = 48'h5555_AAAA_5555;
      pulse(2);
      chk("R4 history word", 48'h5555_AAAA_5555, 1'b0, 1'b0);
   endtask

   task automatic t_fallback();
      mode = 2'd2;
      hist_valid = 1'b0;
      hist_word = 48'h7777_7777_7777;
      open_word = 48'h2222_3333_4444;
      pulse(2);
      chk("R5 history strobe ignored without valid", 48'h5555_AAAA_5555, 1'b0, 1'b0);
      pulse(0);
      chk("R5 fallback to open-loop word", 48'h2222_3333_4444, 1'b0, 1'b0);
   endtask

   task automatic t_ignore();
      mode = 2'd1;
      filt_word = 48'h6666_0000_1111;
      open_word = 48'h0101_0101_0101;
      pulse(0);
      chk("R6 open strobe ignored in locked", 48'h2222_3333_4444, 1'b0, 1'b0);
      hist_valid = 1'b1;
      pulse(2);
      chk("R6 history strobe ignored in locked", 48'h2222_3333_4444, 1'b0, 1'b0);
      mode = 2'd0;
      repeat (2) @(negedge clk);
      chk("R6 mode change alone no update", 48'h2222_3333_4444, 1'b0, 1'b0);
   endtask

   task automatic t_window();
      load_bounds(24'h800000, 24'h100000);
      chk("R11 bound load alone no update", 48'h2222_3333_4444, 1'b0, 1'b0);
      mode = 2'd1;
      filt_word = 48'h9000_0000_1234;
      pulse(1);
      chk("R7 above upper", 48'h8000_0000_0000, 1'b1, 1'b0);
      filt_word = 48'h0500_00FF_FFFF;
      pulse(1);
      chk("R8 below lower", 48'h1000_0000_0000, 1'b0, 1'b1);
      filt_word = 48'h8000_00FF_FFFF;
      pulse(1);
      chk("R9 top equal upper passes", 48'h8000_00FF_FFFF, 1'b0, 1'b0);
      filt_word = 48'h1000_0000_0001;
      pulse(1);
      chk("R9 top equal lower passes", 48'h1000_0000_0001, 1'b0, 1'b0);
      mode = 2'd2;
      hist_valid = 1'b1;
      hist_word = 48'hFFFF_FF00_0000;
      pulse(2);
      chk("R11 clamp in coasting", 48'h8000_0000_0000, 1'b1, 1'b0);
      mode = 2'd0;
      open_word = 48'h0000_0012_3456;
      pulse(0);
      chk("R11 clamp in open loop", 48'h1000_0000_0000, 1'b0, 1'b1);
   endtask

   task automatic t_inverted();
      load_bounds(24'h200000, 24'h300000);
      mode = 2'd1;
      filt_word = 48'h2500_0000_0000;
      pulse(1);
      chk("R10 inverted bounds mid word", 48'h2000_0000_0000, 1'b1, 1'b0);
      filt_word = 48'h0100_0000_0000;
      pulse(1);
      chk("R10 inverted bounds low word", 48'h2000_0000_0000, 1'b1, 1'b0);
      load_bounds(24'hFFFFFF, 24'h000000);
      filt_word = 48'hFEDC_BA98_7654;
      pulse(1);
      chk("R11 restored full window", 48'hFEDC_BA98_7654, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_open_loop();
      t_locked();
      t_coast();
      t_fallback();
      t_ignore();
      t_window();
      t_inverted();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got no completion, expected completion within 20000 cycles");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule